// File: doc/BRIEF.md
# Processor machine-state register unit

This unit keeps the machine-state control word of a small 32-bit processor core. The word holds the trace, vector-prefix, translation, recoverable and byte-order controls. The unit also carries the save/restore register that the exception path uses. When an exception is entered, the saveable controls are copied into the save/restore register. The live word is then narrowed so that the handler runs without tracing and without address translation. A return-from-interrupt copies the saved controls back.

The same unit forms the exception vector address. It takes a 20-bit offset and places either twelve ones or twelve zeros above it, chosen by the prefix control. It also turns instruction-retire strobes into one-cycle single-step and branch trace requests. The prefix control has a boot value, captured while hard reset is held. A later soft reset restores that captured value, whatever the configuration pin shows at that time.

Bit positions below are numbered from the least significant end (index 0 is the LSB): step trace = 10, branch trace = 9, prefix = 6, instruction translation = 5, data translation = 4, recoverable = 1, byte order = 0. All other positions are reserved.

Top module: `msr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit captures `cfg_prefix` as the boot prefix. After that edge, `msr_q` holds only bit 6 equal to `cfg_prefix`, `srr_q` is zero and both trace requests are low.
- R2: A `soft_rst` strobe makes `msr_q` equal to the captured boot prefix in bit 6, with every other bit zero. It also clears `srr_q` and both trace requests. The level of `cfg_prefix` at that moment has no effect.
- R3: A `wr_en` strobe loads `wr_data` into `msr_q` on the next clock edge, keeping only bits 10, 9, 6, 5, 4, 1 and 0. Reserved positions always read zero.
- R4: An `exc_take` strobe copies the saveable bits of `msr_q` into `srr_q`. It clears bits 10, 9, 5, 4 and 1 of `msr_q` and keeps bits 6 and 0.
- R5: An `rfi` strobe loads the saveable bits of `srr_q` into `msr_q`.
- R6: Priority in one cycle runs from soft reset, to exception entry, to return-from-interrupt, to the write strobe. Each lower strobe has no effect when a higher one is present.
- R7: `vec_addr` is `{12'hFFF, vec_off}` when bit 6 is 1 and `{12'h000, vec_off}` when it is 0. It follows the inputs combinationally.
- R8: `step_trap` is high for exactly the cycle after a `retire` strobe that came while bit 10 was 1.
- R9: `branch_trap` is high for exactly the cycle after a `retire` strobe with `retire_is_branch` high while bit 9 was 1. Whether the branch was taken does not matter.
- R10: `xlat_instr`, `xlat_data` and `little_endian` mirror bits 5, 4 and 0.
- R11: When built with `TRACE_EN` = 0, bits 10 and 9 act as reserved: they read zero, they are never saved or restored, and no trace request is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hard reset, active low |
| cfg_prefix | input | 1 | Boot prefix value, captured during hard reset |
| soft_rst | input | 1 | Soft reset strobe |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| exc_take | input | 1 | Exception entry strobe |
| rfi | input | 1 | Return-from-interrupt strobe |
| vec_off | input | 20 | Exception vector offset |
| retire | input | 1 | Instruction retired successfully |
| retire_is_branch | input | 1 | The retired instruction is a branch |
| msr_q | output | 32 | Machine-state word |
| srr_q | output | 32 | Save/restore word |
| vec_addr | output | 32 | Exception vector address |
| step_trap | output | 1 | Single-step trace request pulse |
| branch_trap | output | 1 | Branch trace request pulse |
| xlat_instr | output | 1 | Instruction translation enable |
| xlat_data | output | 1 | Data translation enable |
| little_endian | output | 1 | Little-endian byte order |

## Verification
Exception entry and a software write often arrive in the same cycle. So do exception entry and a return-from-interrupt, or a return and a write. The bench forces each of these pairs in directed cycles and also lets them collide freely under random strobes. After every edge it compares both words against a bench model that applies the stated priority. A retire strobe landing on the same edge as exception entry is judged against the control word as it was before the edge.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int XLEN   = 32;
    localparam int VOFF_W = 20;
    localparam int PFX_W  = XLEN - VOFF_W;

    // bit indices, LSB = 0
    localparam int SE_B = 10;
    localparam int BE_B = 9;
    localparam int IP_B = 6;
    localparam int IR_B = 5;
    localparam int DR_B = 4;
    localparam int RI_B = 1;
    localparam int LE_B = 0;

    typedef struct packed {
        logic [XLEN-1:0] msr;
        logic [XLEN-1:0] srr;
        logic            boot_ip;
        logic            step;
        logic            brch;
    } msr_state_t;

    function automatic logic [XLEN-1:0] save_mask(bit trace_on);
        logic [XLEN-1:0] m;
        m = '0;
        m[IP_B] = 1'b1;
        m[IR_B] = 1'b1;
        m[DR_B] = 1'b1;
        m[RI_B] = 1'b1;
        m[LE_B] = 1'b1;
        if (trace_on) begin
            m[SE_B] = 1'b1;
            m[BE_B] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [XLEN-1:0] entry_keep_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[IP_B] = 1'b1;
        m[LE_B] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/msr_next.sv
module msr_next
    import msr_pkg::*;
#(
    parameter bit TRACE_EN = 1'b1
) (
    input  logic [XLEN-1:0] msr_q,
    input  logic [XLEN-1:0] srr_q,
    input  logic            boot_ip,
    input  logic            soft_rst,
    input  logic            exc_take,
    input  logic            rfi,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] msr_d,
    output logic [XLEN-1:0] srr_d
);
    localparam logic [XLEN-1:0] KEEP = save_mask(TRACE_EN);
    localparam logic [XLEN-1:0] HOLD = entry_keep_mask();

    always_comb begin
        msr_d = msr_q;
        srr_d = srr_q;
        if (soft_rst) begin
            msr_d       = '0;
            msr_d[IP_B] = boot_ip;
            srr_d       = '0;
        end else if (exc_take) begin
            srr_d = msr_q & KEEP;
            msr_d = msr_q & HOLD;
        end else if (rfi) begin
            msr_d = srr_q & KEEP;
        end else if (wr_en) begin
            msr_d = wr_data & KEEP;
        end
    end
endmodule

// File: rtl/msr_trace.sv
module msr_trace #(
    parameter bit TRACE_EN = 1'b1
) (
    input  logic soft_rst,
    input  logic retire,
    input  logic retire_is_branch,
    input  logic se,
    input  logic be,
    output logic step_d,
    output logic brch_d
);
    generate
        if (TRACE_EN) begin : g_trace
            assign step_d = !soft_rst && retire && se;
            assign brch_d = !soft_rst && retire && retire_is_branch && be;
        end else begin : g_notrace
            assign step_d = 1'b0;
            assign brch_d = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/msr_vecgen.sv
module msr_vecgen
    import msr_pkg::*;
(
    input  logic              ip,
    input  logic [VOFF_W-1:0] vec_off,
    output logic [XLEN-1:0]   vec_addr
);
    assign vec_addr = {{PFX_W{ip}}, vec_off};
endmodule

// File: rtl/msr_unit.sv
module msr_unit
    import msr_pkg::*;
#(
    parameter bit TRACE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_prefix,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              exc_take,
    input  logic              rfi,
    input  logic [VOFF_W-1:0] vec_off,
    input  logic              retire,
    input  logic              retire_is_branch,
    output logic [XLEN-1:0]   msr_q,
    output logic [XLEN-1:0]   srr_q,
    output logic [XLEN-1:0]   vec_addr,
    output logic              step_trap,
    output logic              branch_trap,
    output logic              xlat_instr,
    output logic              xlat_data,
    output logic              little_endian
);
    msr_state_t st_d, st_q, st_rst;
    logic [XLEN-1:0] msr_n, srr_n;
    logic step_n, brch_n;

    msr_next #(.TRACE_EN(TRACE_EN)) u_next (
        .msr_q    (st_q.msr),
        .srr_q    (st_q.srr),
        .boot_ip  (st_q.boot_ip),
        .soft_rst (soft_rst),
        .exc_take (exc_take),
        .rfi      (rfi),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .msr_d    (msr_n),
        .srr_d    (srr_n)
    );

    msr_trace #(.TRACE_EN(TRACE_EN)) u_trace (
        .soft_rst         (soft_rst),
        .retire           (retire),
        .retire_is_branch (retire_is_branch),
        .se               (st_q.msr[SE_B]),
        .be               (st_q.msr[BE_B]),
        .step_d           (step_n),
        .brch_d           (brch_n)
    );

    msr_vecgen u_vec (
        .ip       (st_q.msr[IP_B]),
        .vec_off  (vec_off),
        .vec_addr (vec_addr)
    );

    always_comb begin
        st_d         = st_q;
        st_d.msr     = msr_n;
        st_d.srr     = srr_n;
        st_d.step    = step_n;
        st_d.brch    = brch_n;

        st_rst           = '0;
        st_rst.boot_ip   = cfg_prefix;
        st_rst.msr[IP_B] = cfg_prefix;
    end

    always_ff @(posedge clk) begin
        st_q <= rst_n ? st_d : st_rst;
    end

    assign msr_q         = st_q.msr;
    assign srr_q         = st_q.srr;
    assign step_trap     = st_q.step;
    assign branch_trap   = st_q.brch;
    assign xlat_instr    = st_q.msr[IR_B];
    assign xlat_data     = st_q.msr[DR_B];
    assign little_endian = st_q.msr[LE_B];
endmodule

// File: rtl/msr_unit_chk.sv
module msr_unit_chk
    import msr_pkg::*;
#(
    parameter bit TRACE_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              wr_en,
    input logic [XLEN-1:0]   wr_data,
    input logic              exc_take,
    input logic              rfi,
    input logic [VOFF_W-1:0] vec_off,
    input logic              retire,
    input logic [XLEN-1:0]   msr_q,
    input logic [XLEN-1:0]   srr_q,
    input logic [XLEN-1:0]   vec_addr,
    input logic              step_trap,
    input logic              branch_trap
);
    localparam logic [XLEN-1:0] KEEP = save_mask(TRACE_EN);
    localparam logic [XLEN-1:0] CLRD = save_mask(TRACE_EN) & ~entry_keep_mask();

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_q & ~KEEP) == '0);

    a_r3_write_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exc_take && !rfi && !soft_rst) |=> msr_q == ($past(wr_data) & KEEP));

    a_r4_entry_save: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && !soft_rst) |=> srr_q == ($past(msr_q) & KEEP));

    a_r4_entry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && !soft_rst) |=> (msr_q & CLRD) == '0);

    a_r5_return_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi && !exc_take && !soft_rst) |=> msr_q == ($past(srr_q) & KEEP));

    a_r7_vec_low: assert property (@(posedge clk) disable iff (!rst_n)
        vec_addr[VOFF_W-1:0] == vec_off);

    a_r8_step_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_trap) |-> $past(retire));

    a_r9_branch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(branch_trap) |-> $past(retire));

    a_r2_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (srr_q == '0 && !step_trap && !branch_trap));
endmodule

bind msr_unit msr_unit_chk #(.TRACE_EN(TRACE_EN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .exc_take    (exc_take),
    .rfi         (rfi),
    .vec_off     (vec_off),
    .retire      (retire),
    .msr_q       (msr_q),
    .srr_q       (srr_q),
    .vec_addr    (vec_addr),
    .step_trap   (step_trap),
    .branch_trap (branch_trap)
);

// File: tb/sim_msr_unit.sv
`timescale 1ns/1ps
module sim_msr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_prefix = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        exc_take = 1'b0;
    logic        rfi = 1'b0;
    logic [19:0] vec_off = '0;
    logic        retire = 1'b0;
    logic        retire_is_branch = 1'b0;

    logic [31:0] msr0, srr0, vec0, msr1, srr1, vec1;
    logic        stp0, brt0, xi0, xd0, le0, stp1, brt1, xi1, xd1, le1;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // bench model, two builds
    logic [31:0] m_msr, m_srr, t_msr, t_srr;
    logic        m_boot, m_step, m_br;

    always #10 clk = ~clk;

    msr_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_prefix(cfg_prefix), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_data(wr_data), .exc_take(exc_take), .rfi(rfi),
        .vec_off(vec_off), .retire(retire), .retire_is_branch(retire_is_branch),
        .msr_q(msr0), .srr_q(srr0), .vec_addr(vec0), .step_trap(stp0),
        .branch_trap(brt0), .xlat_instr(xi0), .xlat_data(xd0), .little_endian(le0)
    );

    msr_unit #(.TRACE_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_prefix(cfg_prefix), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_data(wr_data), .exc_take(exc_take), .rfi(rfi),
        .vec_off(vec_off), .retire(retire), .retire_is_branch(retire_is_branch),
        .msr_q(msr1), .srr_q(srr1), .vec_addr(vec1), .step_trap(stp1),
        .branch_trap(brt1), .xlat_instr(xi1), .xlat_data(xd1), .little_endian(le1)
    );

    function automatic logic [31:0] keep(bit tr);
        return tr ? 32'h0000_0673 : 32'h0000_0073;
    endfunction

    function automatic logic [31:0] exp_vec(logic [31:0] m, logic [19:0] off);
        return {m[6] ? 12'hFFF : 12'h000, off};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [31:0] nm, ns, tm, ts;
        if (!rst_n) begin
            m_boot = cfg_prefix;
            m_msr = {25'd0, cfg_prefix, 6'd0};
            m_srr = '0;
            t_msr = m_msr;
            t_srr = '0;
            m_step = 1'b0;
            m_br = 1'b0;
            return;
        end
        m_step = !soft_rst && retire && m_msr[10];
        m_br   = !soft_rst && retire && retire_is_branch && m_msr[9];
        nm = m_msr; ns = m_srr; tm = t_msr; ts = t_srr;
        if (soft_rst) begin
            nm = {25'd0, m_boot, 6'd0}; ns = '0;
            tm = nm; ts = '0;
        end else if (exc_take) begin
            ns = m_msr & keep(1); nm = m_msr & 32'h41;
            ts = t_msr & keep(0); tm = t_msr & 32'h41;
        end else if (rfi) begin
            nm = m_srr & keep(1);
            tm = t_srr & keep(0);
        end else if (wr_en) begin
            nm = wr_data & keep(1);
            tm = wr_data & keep(0);
        end
        m_msr = nm; m_srr = ns; t_msr = tm; t_srr = ts;
    endtask

    task automatic compare_all(string tag);
        chk(tag, msr0, m_msr);
        chk("R4", srr0, m_srr);
        chk("R7", vec0, exp_vec(m_msr, vec_off));
        chk("R8", {31'd0, stp0}, {31'd0, m_step});
        chk("R9", {31'd0, brt0}, {31'd0, m_br});
        chk("R10", {29'd0, xi0, xd0, le0}, {29'd0, m_msr[5], m_msr[4], m_msr[0]});
        chk("R11", msr1, t_msr);
        chk("R11", srr1, t_srr);
        chk("R11", {30'd0, stp1, brt1}, 32'd0);
    endtask

    // inputs were set after a falling edge; register them, then sample at the next falling edge
    task automatic tick(string tag);
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle();
        soft_rst = 0; wr_en = 0; exc_take = 0; rfi = 0; retire = 0; retire_is_branch = 0;
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5117));
        @(negedge clk);
        // R1: boot with prefix high
        rst_n = 0; cfg_prefix = 1; idle();
        tick("R1");
        tick("R1");
        rst_n = 1;
        tick("R1");
        chk("R1", msr0, 32'h0000_0040);
        chk("R7", vec0[31:20], 32'hFFF);

        // R2: pin changes, soft reset restores the captured value
        cfg_prefix = 0; wr_en = 1; wr_data = 32'h0;
        tick("R3");
        chk("R3", msr0, 32'h0);
        idle(); soft_rst = 1;
        tick("R2");
        chk("R2", msr0, 32'h0000_0040);
        idle();

        // R3 / R11: all-ones write masks reserved bits
        wr_en = 1; wr_data = 32'hFFFF_FFFF;
        tick("R3");
        chk("R3", msr0, 32'h0000_0673);
        chk("R11", msr1, 32'h0000_0073);
        idle();

        // R6: exception beats write in the same cycle
        exc_take = 1; wr_en = 1; wr_data = 32'h0000_0000;
        tick("R6");
        chk("R4", srr0, 32'h0000_0673);
        chk("R6", msr0, 32'h0000_0041);
        idle();

        // R6: exception beats return
        exc_take = 1; rfi = 1;
        tick("R6");
        chk("R6", msr0, 32'h0000_0041);
        idle();

        // R5: return restores saved word; return beats write
        wr_en = 1; wr_data = 32'h0000_0630;
        tick("R3");
        exc_take = 1; wr_en = 0;
        tick("R4");
        chk("R4", srr0, 32'h0000_0630);
        idle(); rfi = 1; wr_en = 1; wr_data = 32'h1;
        tick("R5");
        chk("R5", msr0, 32'h0000_0630);
        idle();

        // R8 / R9: step and branch pulses, branch not taken still counts
        retire = 1; retire_is_branch = 1;
        tick("R8");
        chk("R8", {31'd0, stp0}, 32'd1);
        chk("R9", {31'd0, brt0}, 32'd1);
        idle();
        tick("R8");
        chk("R8", {31'd0, stp0}, 32'd0);
        chk("R9", {31'd0, brt0}, 32'd0);
        retire = 1; retire_is_branch = 0;
        tick("R9");
        chk("R9", {31'd0, brt0}, 32'd0);
        chk("R8", {31'd0, stp0}, 32'd1);
        idle();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            rst_n            = ($urandom % 600) != 0;
            cfg_prefix       = $urandom % 2;
            soft_rst         = ($urandom % 50) == 0;
            exc_take         = ($urandom % 7) == 0;
            rfi              = ($urandom % 7) == 0;
            wr_en            = ($urandom % 3) == 0;
            wr_data          = $urandom;
            vec_off          = 20'($urandom);
            retire           = $urandom % 2;
            retire_is_branch = ($urandom % 3) == 0;
            tick("R3");
        end
        rst_n = 1; idle();
        tick("R3");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule